// File: doc/BRIEF.md
# Windowed Digital Lock Detector

This block decides whether one or more phase-locked loops are frequency-locked. It watches each loop's divided reference and divided feedback edge streams. Both streams are synchronised into a fast sampling clock. Each reference rising edge is paired with the nearest unmatched feedback rising edge, and the time between the two edges is measured in sampling-clock ticks. A pair is "in window" when its separation does not exceed a programmable window size. A run of consecutive in-window pairs, as long as a programmable lock count, raises the loop's lock flag. A single out-of-window pair clears both the run and the flag.

The window width and the run length together set the frequency accuracy that the loop must reach. Because each pair comes from one phase-detector cycle, the shortest time to lock is the lock count divided by the phase-detector rate. If the lock count is too short, the lock flag toggles on and off while the loop is settling. Each loop has its own window size and lock count, written through a small register port.

Top module: `lock_window_detect`

## Requirements
- R1: A synchronous active-high reset clears every loop's run counter, lock flag, lock pulse, in-window strobe and pairing state. It also loads the window size with `DEF_WIN` and the lock count with `DEF_LOCK`.
- R2: Each edge input passes through a two-flop synchroniser, and only a rising edge is used. A pair is reported at the second clock edge after the edge that first samples the later input of the pair high.
- R3: A pair's separation is the number of clock ticks between the two rising edges, whichever side comes first. The pair is in window when the separation is at most the window size. That case gives a one-cycle `in_win_stb` pulse; any other pair gives none.
- R4: Each in-window pair increments the loop's run counter. The counter saturates at the lock count and never goes above it.
- R5: The lock flag goes high on the in-window pair that brings the run to the lock count. `lock_pulse` is high for exactly that one cycle, and the flag stays high while further pairs remain in window.
- R6: An out-of-window pair clears the run counter and the lock flag at the same edge that would report the pair.
- R7: A second rising edge on the same side, before the other side has answered, counts as an out-of-window cycle. That new edge then becomes the pending edge.
- R8: Writing with `cfg_we` high targets the loop named by `cfg_loop`. With `cfg_sel`=0 the write sets the window size from the low `WIN_W` bits of `cfg_wdata`; with `cfg_sel`=1 it sets the lock count. Either write clears that loop's run counter and lock flag and leaves every other loop untouched.
- R9: Reference and feedback edges that rise in the same cycle form a pair with separation 0, which is always in window.
- R10: When the lock count is 0, the first in-window pair locks the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | NLOOP | Divided reference edge stream, one bit per loop |
| fb_in | input | NLOOP | Divided feedback edge stream, one bit per loop |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_loop | input | LW | Index of the loop being written |
| cfg_sel | input | 1 | 0 selects the window size, 1 selects the lock count |
| cfg_wdata | input | CNT_W | Configuration write data |
| locked | output | NLOOP | Lock flag per loop |
| lock_pulse | output | NLOOP | One-cycle pulse when a loop becomes locked |
| in_win_stb | output | NLOOP | One-cycle strobe for each in-window pair |

## Verification
The bench builds the block with two loops, an 8-bit window and a 16-bit counter. It lowers the reset lock count to 3, so a loop locks, saturates and unlocks within a few dozen pairs. Separations of exactly the window size and one tick more are both in reach, as are feedback-first pairs, duplicated reference edges and coincident edges. A lock count of 0 on the second loop exercises immediate lock, while the first loop is checked to stay unaffected by that write.

// File: rtl/lock_window_detect.sv
module lock_window_detect #(
  parameter int NLOOP = 2,
  parameter int WIN_W = 8,
  parameter int CNT_W = 16,
  parameter logic [WIN_W-1:0] DEF_WIN = 8'd4,
  parameter logic [CNT_W-1:0] DEF_LOCK = 16'd8,
  localparam int LW = (NLOOP > 1) ? $clog2(NLOOP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLOOP-1:0] ref_in,
  input  logic [NLOOP-1:0] fb_in,
  input  logic             cfg_we,
  input  logic [LW-1:0]    cfg_loop,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [NLOOP-1:0] locked,
  output logic [NLOOP-1:0] lock_pulse,
  output logic [NLOOP-1:0] in_win_stb
);

  logic [NLOOP-1:0][CNT_W-1:0] run_q;
  logic [NLOOP-1:0][CNT_W-1:0] lck_q;

  for (genvar i = 0; i < NLOOP; i++) begin : g_loop
    logic [2:0] rs, fs;
    logic pr, pf, lk, inw, lp;
    logic [WIN_W-1:0] age, win;
    logic [CNT_W-1:0] run, lck;

    wire rr = rs[1] & ~rs[2];
    wire fr = fs[1] & ~fs[2];
    wire idle = ~pr & ~pf;
    wire pair = (pr & fr) | (pf & rr) | (idle & rr & fr);
    wire dup = (pr & rr & ~fr) | (pf & fr & ~rr);
    wire [WIN_W:0] sep = (idle & rr & fr) ? '0 : {1'b0, age} + 1'b1;
    wire hit = pair & (sep <= {1'b0, win});
    wire miss = (pair & ~hit) | dup;
    wire wr_me = cfg_we & (cfg_loop == LW'(i));
    wire [CNT_W-1:0] run_n = (run >= lck) ? lck : run + 1'b1;
    wire reach = run_n >= lck;

    always_ff @(posedge clk) begin
      if (rst) begin
        rs <= '0; fs <= '0;
        pr <= 1'b0; pf <= 1'b0; age <= '0;
        run <= '0; lk <= 1'b0; inw <= 1'b0; lp <= 1'b0;
        win <= DEF_WIN; lck <= DEF_LOCK;
      end else begin
        rs <= {rs[1:0], ref_in[i]};
        fs <= {fs[1:0], fb_in[i]};
        if (pr) begin
          if (rr) age <= '0;
          else if (fr) pr <= 1'b0;
          else if (~&age) age <= age + 1'b1;
        end else if (pf) begin
          if (fr) age <= '0;
          else if (rr) pf <= 1'b0;
          else if (~&age) age <= age + 1'b1;
        end else if (rr & ~fr) begin
          pr <= 1'b1; age <= '0;
        end else if (fr & ~rr) begin
          pf <= 1'b1; age <= '0;
        end
        inw <= hit;
        lp <= 1'b0;
        if (wr_me) begin
          if (cfg_sel) lck <= cfg_wdata;
          else win <= cfg_wdata[WIN_W-1:0];
          run <= '0; lk <= 1'b0;
        end else if (hit) begin
          run <= run_n; lk <= reach; lp <= ~lk & reach;
        end else if (miss) begin
          run <= '0; lk <= 1'b0;
        end
      end
    end

    assign locked[i] = lk;
    assign lock_pulse[i] = lp;
    assign in_win_stb[i] = inw;
    assign run_q[i] = run;
    assign lck_q[i] = lck;
  end

endmodule

module lock_window_checks #(
  parameter int NLOOP = 2,
  parameter int CNT_W = 16
) (
  input logic clk,
  input logic rst,
  input logic [NLOOP-1:0] locked,
  input logic [NLOOP-1:0] lock_pulse,
  input logic [NLOOP-1:0] in_win_stb,
  input logic [NLOOP-1:0][CNT_W-1:0] run_q,
  input logic [NLOOP-1:0][CNT_W-1:0] lck_q
);
  for (genvar i = 0; i < NLOOP; i++) begin : g_chk
    p_lock_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(locked[i]) |-> in_win_stb[i]);
    p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
      lock_pulse[i] |-> (locked[i] && !$past(locked[i])));
    p_rise_has_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(locked[i]) |-> lock_pulse[i]);
    p_run_capped_r4: assert property (@(posedge clk) disable iff (rst)
      run_q[i] <= lck_q[i]);
    p_drop_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(locked[i]) |-> (run_q[i] == '0));
  end
endmodule

bind lock_window_detect lock_window_checks #(.NLOOP(NLOOP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .locked(locked), .lock_pulse(lock_pulse),
  .in_win_stb(in_win_stb), .run_q(run_q), .lck_q(lck_q)
);

// File: tb/tb_lock_window_detect.sv
module tb_lock_window_detect;
  localparam int NL = 2;
  localparam int DEFW = 4;
  localparam int DEFL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] ref_in = '0, fb_in = '0;
  logic cfg_we = 1'b0;
  logic [0:0] cfg_loop = '0;
  logic cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [NL-1:0] locked, lock_pulse, in_win_stb;

  lock_window_detect #(.NLOOP(NL), .WIN_W(8), .CNT_W(16),
    .DEF_WIN(8'(DEFW)), .DEF_LOCK(16'(DEFL))) dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .cfg_we(cfg_we),
    .cfg_loop(cfg_loop), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .locked(locked), .lock_pulse(lock_pulse), .in_win_stb(in_win_stb));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural model: sample history queues and integer state
  bit rq[NL][$], fq[NL][$];
  int pend[NL], age[NL], run[NL], win[NL], lck[NL];
  bit m_lk[NL], m_lp[NL], m_iw[NL];

  always @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst) begin
        rq[i].delete(); fq[i].delete();
        repeat (3) begin rq[i].push_back(1'b0); fq[i].push_back(1'b0); end
        pend[i] = 0; age[i] = 0; run[i] = 0; win[i] = DEFW; lck[i] = DEFL;
        m_lk[i] = 0; m_lp[i] = 0; m_iw[i] = 0;
      end else begin
        bit r_e, f_e, pr_, hit, miss;
        int sep;
        // edges seen now: sampled two and three edges ago
        r_e = rq[i][1] && !rq[i][0];
        f_e = fq[i][1] && !fq[i][0];
        hit = 0; miss = 0;
        pr_ = 0; sep = 0;
        if (pend[i] == 0 && r_e && f_e) begin pr_ = 1; sep = 0; end
        else if ((pend[i] == 1 && f_e) || (pend[i] == 2 && r_e)) begin pr_ = 1; sep = age[i] + 1; end
        if (pr_) begin hit = (sep <= win[i]); miss = !hit; end
        if ((pend[i] == 1 && r_e && !f_e) || (pend[i] == 2 && f_e && !r_e)) miss = 1;
        if (pend[i] == 1) begin
          if (r_e) age[i] = 0; else if (f_e) pend[i] = 0; else if (age[i] < 255) age[i]++;
        end else if (pend[i] == 2) begin
          if (f_e) age[i] = 0; else if (r_e) pend[i] = 0; else if (age[i] < 255) age[i]++;
        end else if (r_e && !f_e) begin pend[i] = 1; age[i] = 0; end
        else if (f_e && !r_e) begin pend[i] = 2; age[i] = 0; end
        m_iw[i] = hit; m_lp[i] = 0;
        if (cfg_we && cfg_loop == 1'(i)) begin
          if (cfg_sel) lck[i] = cfg_wdata; else win[i] = cfg_wdata[7:0];
          run[i] = 0; m_lk[i] = 0;
        end else if (hit) begin
          int rn;
          rn = (run[i] >= lck[i]) ? lck[i] : run[i] + 1;
          m_lp[i] = !m_lk[i] && rn >= lck[i];
          run[i] = rn; m_lk[i] = rn >= lck[i];
        end else if (miss) begin
          run[i] = 0; m_lk[i] = 0;
        end
        void'(rq[i].pop_front()); void'(fq[i].pop_front());
      end
      rq[i].push_back(ref_in[i]); fq[i].push_back(fb_in[i]);
      if (rst) begin void'(rq[i].pop_front()); void'(fq[i].pop_front()); end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    for (int i = 0; i < NL; i++) begin
      chk(cur_req, $sformatf("locked[%0d] (R5)", i), locked[i], m_lk[i]);
      chk(cur_req, $sformatf("lock_pulse[%0d] (R5)", i), lock_pulse[i], m_lp[i]);
      chk(cur_req, $sformatf("in_win_stb[%0d] (R3)", i), in_win_stb[i], m_iw[i]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // reference rises at tick dr, feedback at tick df, each high two ticks
  task automatic pulse_pair(int i, int dr, int df);
    int last;
    last = ((dr > df) ? dr : df) + 3;
    for (int t = 0; t <= last; t++) begin
      ref_in[i] = (t >= dr && t < dr + 2);
      fb_in[i] = (t >= df && t < df + 2);
      @(negedge clk);
    end
    ref_in[i] = 0; fb_in[i] = 0;
    idle(4);
  endtask

  task automatic one_side(int i, bit is_ref);
    if (is_ref) ref_in[i] = 1; else fb_in[i] = 1;
    idle(2);
    ref_in[i] = 0; fb_in[i] = 0;
    idle(3);
  endtask

  task automatic cfg(int i, bit sel, int val);
    cfg_loop = 1'(i); cfg_sel = sel; cfg_wdata = 16'(val); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    idle(2);
  endtask

  bit timed_out = 0;
  initial begin
    #(8 * 50000);
    timed_out = 1;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 0;
    cur_req = "R1";
    chk("R1", "locked after reset", locked, 0);
    chk("R1", "lock_pulse after reset", lock_pulse, 0);
    chk("R1", "in_win_stb after reset", in_win_stb, 0);

    // R2/R3/R4/R5: three in-window pairs reach lock
    cur_req = "R5";
    pulse_pair(0, 0, 2);
    pulse_pair(0, 0, 3);
    chk("R4", "not locked before lock count", locked[0], 0);
    pulse_pair(0, 0, 1);
    chk("R5", "locked after 3 in-window pairs", locked[0], 1);
    // R4 saturation: more pairs keep lock, no new pulse (model compares)
    cur_req = "R4";
    repeat (4) pulse_pair(0, 0, 2);
    chk("R4", "still locked at saturation", locked[0], 1);

    // R3 boundary: separation equal to window stays in, one more drops (R6)
    cur_req = "R3";
    pulse_pair(0, 0, DEFW);
    chk("R3", "separation == window keeps lock", locked[0], 1);
    cur_req = "R6";
    pulse_pair(0, 0, DEFW + 1);
    chk("R6", "separation window+1 drops lock", locked[0], 0);

    // R3 feedback first, R2 timing via per-cycle model
    cur_req = "R3";
    repeat (3) pulse_pair(0, 3, 0);
    chk("R3", "feedback-first pairs lock", locked[0], 1);

    // R7 duplicate reference edge
    cur_req = "R7";
    one_side(0, 1);
    one_side(0, 1);
    chk("R7", "duplicate reference edge drops lock", locked[0], 0);
    one_side(0, 0);
    idle(4);

    // R9 coincident edges
    cur_req = "R9";
    repeat (3) pulse_pair(0, 0, 0);
    chk("R9", "coincident edges lock", locked[0], 1);

    // R10 / R8: loop 1 lock count 0, window 1; loop 0 untouched
    cur_req = "R10";
    cfg(1, 1, 0);
    cfg(1, 0, 1);
    chk("R8", "loop0 unaffected by loop1 write", locked[0], 1);
    pulse_pair(1, 0, 1);
    chk("R10", "lock count 0 locks on first pair", locked[1], 1);
    cur_req = "R8";
    pulse_pair(1, 0, 2);
    chk("R8", "loop1 window 1 rejects separation 2", locked[1], 0);
    cfg(0, 0, 10);
    chk("R8", "write clears loop0 lock", locked[0], 0);
    pulse_pair(0, 0, 9);
    pulse_pair(0, 0, 10);
    pulse_pair(0, 10, 0);
    chk("R8", "loop0 window 10 locks", locked[0], 1);

    // R1 reset in the middle
    cur_req = "R1";
    @(negedge clk) rst = 1;
    idle(2);
    @(negedge clk) rst = 0;
    chk("R1", "reset clears lock", locked, 0);
    pulse_pair(0, 0, DEFW + 1);
    chk("R1", "window back to default after reset", in_win_stb[0], 0);
    idle(5);
    finish_run();
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (timed_out) begin
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule